// File: doc/BRIEF.md
# Multi-mode serial line encoder

This block converts a serial bit stream into a ternary line signal. An external timing source pulses a half-bit strobe twice per bit period. On the first strobe of each bit the block samples the data input. On every strobe it emits one signed two-bit line symbol, so each bit produces a pair of symbols, one for each half of the bit period. A four-bit selector picks one of nine line codes. Three are two-level codes (non-return-to-zero level, non-return-to-zero inverted, Manchester), two are transition or return-to-zero codes (differential Manchester, unipolar return-to-zero), and four are ternary codes (alternate mark inversion, pseudoternary, and the two zero-substitution variants of alternate mark inversion with eight-zero and four-zero runs).

The two zero-substitution codes need to know whether a run of zeros is complete before they emit its first symbol. For that reason they pass the data through a lookahead buffer, eight bits deep for the eight-zero code and four bits deep for the four-zero code. Every other code has no added delay. Writing a new value to the selector restarts the encoder. All code state is cleared and the next strobe is treated as the first half of a fresh bit.

Top module: `multicode_line_enc`

## Requirements
- R1: Each emitted symbol is one of three level codes: 00 for zero, 01 for positive and 11 for negative. The code 10 never appears. The selector values are: 0 unipolar RZ, 1 NRZ-L, 2 NRZ-I, 3 Manchester, 4 differential Manchester, 5 AMI, 6 pseudoternary, 7 eight-zero substitution, 9 four-zero substitution.
- R2: A strobe that does not fall in a selector-change cycle updates `sym_out` at the next clock edge. In that case `sym_vld` is high for exactly that one following cycle, and it is low otherwise. Strobes alternate between first half and second half, starting with the first half after reset or a selector change. `bit_in` is sampled only on first-half strobes.
- R3: Unipolar RZ sends a 1 as 01 then 00, and a 0 as 00 then 00.
- R4: NRZ-L sends a 1 as 11 and a 0 as 01, in both halves. NRZ-I holds a level that starts at negative and inverts on every 1. It sends the held level (after any inversion) in both halves, so the first 1 gives 01.
- R5: Manchester sends a 1 as 01 then 11, and a 0 as 11 then 01.
- R6: Differential Manchester has a flag that starts at 0. When the input bit differs from the flag, the bit is sent as 01 then 11. When the input bit equals the flag, the bit is sent as 11 then 01. After each bit the flag becomes the flag XOR the bit.
- R7: AMI sends a 0 as 00 in both halves. Each 1 is sent as a full-period pulse that alternates in sign, and the first 1 is positive (01).
- R8: Pseudoternary sends a 1 as 00 in both halves. Each 0 is sent as a full-period pulse that alternates in sign, and the first 0 is positive (01).
- R9: Eight-zero substitution emits each bit 8 bit periods after it is sampled, using AMI rules. Every run of eight zeros not already substituted is replaced, where P is the sign of the last pulse: P sits at run positions 4 and 8, minus P at positions 5 and 7, and zero elsewhere. After a negative pulse the run is 000-+0+-, and after a positive pulse it is 000+-0-+. The AMI sign state is unchanged by a substitution. Before any pulse, the last pulse counts as negative.
- R10: Four-zero substitution emits each bit 4 bit periods after it is sampled, using AMI rules. Every run of four zeros not already substituted is replaced. If an odd number of pulses has been sent since the last violation, the run becomes 000V. If an even number has been sent, it becomes B00V. B is an ordinary alternating pulse and counts as a pulse. V has the sign of the preceding pulse, does not alter the alternation, and clears the count. The count starts even, and the last pulse starts as negative.
- R11: A selector change clears all code state: the sign, the parity, the differential flag, the NRZ-I level, the half phase and the lookahead buffer. Selector values 8 and 10 to 15 emit 00 in both halves.
- R12: After reset or a selector change, the first 8 bit periods (eight-zero code) or 4 bit periods (four-zero code) emit 00 in both halves. Bits sampled during that fill do not start a zero run with the fill slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Serial data, sampled on first-half strobes |
| half_tick | input | 1 | One-cycle strobe marking the start of each half-bit interval |
| mode | input | 4 | Line code selector |
| sym_out | output | 2 | Signed line symbol (00 zero, 01 positive, 11 negative) |
| sym_vld | output | 1 | High for the one cycle after a strobe that produced a symbol |

## Verification
A wrong sign or parity state in this encoder does not show at once; it shows at the next event that reads it. A stuck alternation shows as two pulses of equal sign at the next mark. A wrong parity shows as the wrong four-zero pattern (000V against B00V), at the next four-zero run it reaches, four bit periods after the run's first zero is sampled. A mistagged lookahead slot shows only when that slot reaches the output, eight or four bit periods after sampling. Leaving state behind on a selector change shows at the first pulse or transition of the new stream. The streams are therefore built with long zero runs after both odd and even pulse counts. Each stream also ends with a non-default code state before the next selector change.

// File: rtl/mcle_pkg.sv
// Shared types and constants for the multi-mode line encoder.
// Assumes the eight-zero code sets the deepest lookahead (8 slots).
package mcle_pkg;

    typedef logic [1:0] level_t;
    localparam level_t LVL_ZERO = 2'b00;
    localparam level_t LVL_POS  = 2'b01;
    localparam level_t LVL_NEG  = 2'b11;

    localparam logic [3:0] CODE_RZ     = 4'd0;
    localparam logic [3:0] CODE_NRZL   = 4'd1;
    localparam logic [3:0] CODE_NRZI   = 4'd2;
    localparam logic [3:0] CODE_MAN    = 4'd3;
    localparam logic [3:0] CODE_DMAN   = 4'd4;
    localparam logic [3:0] CODE_AMI    = 4'd5;
    localparam logic [3:0] CODE_PSEUDO = 4'd6;
    localparam logic [3:0] CODE_SUB8   = 4'd7;
    localparam logic [3:0] CODE_SUB4   = 4'd9;

    localparam int LONG_RUN  = 8;
    localparam int SHORT_RUN = 4;
    localparam int POS_W     = $clog2(LONG_RUN);

    // One lookahead slot: filled flag, data bit, substitution tag, run position.
    typedef struct packed {
        logic             full;
        logic             dat;
        logic             sub;
        logic [POS_W-1:0] pos;
    } slot_t;

    // Code state shared by all modes; cleared on a selector change.
    typedef struct packed {
        logic pol;   // 1: last pulse positive, next mark negative
        logic par;   // odd pulse count since last violation
        logic dm;    // differential Manchester flag
        logic lvl;   // NRZ-I held level, 1 = positive
    } cstate_t;

    // Sign of the next alternating mark.
    function automatic level_t next_mark(input logic pol);
        return pol ? LVL_NEG : LVL_POS;
    endfunction

    // Sign of the most recent pulse.
    function automatic level_t last_mark(input logic pol);
        return pol ? LVL_POS : LVL_NEG;
    endfunction

    // Opposite level; zero stays zero.
    function automatic level_t invert(input level_t lv);
        return (lv == LVL_POS) ? LVL_NEG : ((lv == LVL_NEG) ? LVL_POS : LVL_ZERO);
    endfunction

endpackage

// File: rtl/mcle_lookahead.sv
// Lookahead shift buffer for the zero-substitution codes.
// A new bit enters slot 0 on each push; the tap is slot RUN-1, so a bit is
// emitted RUN pushes after it entered. When the pushed zero completes a run of
// RUN untagged zeros, all RUN slots of that run are tagged with their position.
// Assumes SHORT >= 2 and DEPTH > SHORT.
module mcle_lookahead
    import mcle_pkg::*;
#(
    parameter int DEPTH = LONG_RUN,
    parameter int SHORT = SHORT_RUN
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  push,
    input  logic  din,
    input  logic  short_run,
    output slot_t tap
);

    slot_t            q   [DEPTH];
    slot_t            nxt [DEPTH];
    logic [DEPTH-2:0] cand;
    logic [DEPTH-2:0] pref;
    logic             hit;
    int               run_len;

    // Mark slots holding an untagged, filled zero and chain them from slot 0.
    always_comb begin
        for (int i = 0; i < DEPTH - 1; i++) begin
            cand[i] = q[i].full & ~q[i].dat & ~q[i].sub;
        end
        pref[0] = cand[0];
        for (int i = 1; i < DEPTH - 1; i++) begin
            pref[i] = pref[i-1] & cand[i];
        end
    end

    // Run completion check for the selected run length.
    always_comb begin
        run_len = short_run ? SHORT : DEPTH;
        hit     = push & ~din & (short_run ? pref[SHORT-2] : pref[DEPTH-2]);
    end

    // Shifted contents with run tags applied on a completed run.
    always_comb begin
        nxt[0] = '{full: 1'b1, dat: din, sub: 1'b0, pos: '0};
        for (int i = 1; i < DEPTH; i++) begin
            nxt[i] = q[i-1];
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (hit && (i < run_len)) begin
                nxt[i].sub = 1'b1;
                nxt[i].pos = POS_W'(run_len - 1 - i);
            end
        end
    end

    // Buffer register: cleared on reset or selector change, shifted on push.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < DEPTH; i++) begin
                q[i] <= '0;
            end
        end else if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                q[i] <= nxt[i];
            end
        end
    end

    // Output tap at the depth of the selected run.
    always_comb begin
        tap = short_run ? q[SHORT-1] : q[DEPTH-1];
    end

endmodule

// File: rtl/mcle_symmap.sv
// Combinational symbol mapper: given the selector, the direct data bit, the
// lookahead tap and the code state, returns both half-bit symbols of the
// current bit and the next code state. The eight-zero pattern assumes a run
// of eight slots (positions 0..7).
module mcle_symmap
    import mcle_pkg::*;
(
    input  logic [3:0] mode,
    input  logic       dat,
    input  slot_t      slot,
    input  cstate_t    st,
    output level_t     first,
    output level_t     second,
    output cstate_t    st_nx
);

    // Per-code level selection and state update.
    always_comb begin
        first  = LVL_ZERO;
        second = LVL_ZERO;
        st_nx  = st;
        case (mode)
            CODE_RZ: begin
                first = dat ? LVL_POS : LVL_ZERO;
            end
            CODE_NRZL: begin
                first  = dat ? LVL_NEG : LVL_POS;
                second = first;
            end
            CODE_NRZI: begin
                st_nx.lvl = st.lvl ^ dat;
                first     = st_nx.lvl ? LVL_POS : LVL_NEG;
                second    = first;
            end
            CODE_MAN: begin
                first  = dat ? LVL_POS : LVL_NEG;
                second = invert(first);
            end
            CODE_DMAN: begin
                first    = (dat ^ st.dm) ? LVL_POS : LVL_NEG;
                second   = invert(first);
                st_nx.dm = st.dm ^ dat;
            end
            CODE_AMI: begin
                if (dat) begin
                    first     = next_mark(st.pol);
                    st_nx.pol = ~st.pol;
                end
                second = first;
            end
            CODE_PSEUDO: begin
                if (!dat) begin
                    first     = next_mark(st.pol);
                    st_nx.pol = ~st.pol;
                end
                second = first;
            end
            CODE_SUB8, CODE_SUB4: begin
                if (slot.full) begin
                    if (slot.dat) begin
                        first     = next_mark(st.pol);
                        st_nx.pol = ~st.pol;
                        st_nx.par = ~st.par;
                    end else if (slot.sub && (mode == CODE_SUB8)) begin
                        if (slot.pos == POS_W'(3) || slot.pos == POS_W'(7)) begin
                            first = last_mark(st.pol);
                        end else if (slot.pos == POS_W'(4) || slot.pos == POS_W'(6)) begin
                            first = next_mark(st.pol);
                        end
                    end else if (slot.sub) begin
                        if (slot.pos == '0 && !st.par) begin
                            first     = next_mark(st.pol);
                            st_nx.pol = ~st.pol;
                            st_nx.par = 1'b1;
                        end else if (slot.pos == POS_W'(SHORT_RUN - 1)) begin
                            first     = last_mark(st.pol);
                            st_nx.par = 1'b0;
                        end
                    end
                end
                second = first;
            end
            default: begin
                first  = LVL_ZERO;
                second = LVL_ZERO;
            end
        endcase
    end

endmodule

// File: rtl/multicode_line_enc.sv
// Multi-mode serial line encoder top. Tracks the half-bit phase, restarts on
// a selector change, drives the lookahead buffer on first-half strobes and
// registers one symbol per strobe. Assumes strobes are at least one cycle apart
// and that mode is stable while a stream is sent.
module multicode_line_enc
    import mcle_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_in,
    input  logic       half_tick,
    input  logic [3:0] mode,
    output logic [1:0] sym_out,
    output logic       sym_vld
);

    logic [3:0] mode_q;
    logic       phase_q;
    cstate_t    st_q;
    cstate_t    st_nx;
    level_t     second_q;
    level_t     first_c;
    level_t     second_c;
    slot_t      tap;
    logic       chg;
    logic       push;

    // Selector change detection and first-half push qualification.
    always_comb begin
        chg  = (mode != mode_q);
        push = half_tick & ~chg & ~phase_q;
    end

    mcle_lookahead #(
        .DEPTH (LONG_RUN),
        .SHORT (SHORT_RUN)
    ) u_look (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (chg),
        .push      (push),
        .din       (bit_in),
        .short_run (mode_q == CODE_SUB4),
        .tap       (tap)
    );

    mcle_symmap u_map (
        .mode   (mode_q),
        .dat    (bit_in),
        .slot   (tap),
        .st     (st_q),
        .first  (first_c),
        .second (second_c),
        .st_nx  (st_nx)
    );

    // Phase, code state and output symbol registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= CODE_RZ;
            phase_q  <= 1'b0;
            st_q     <= '0;
            second_q <= LVL_ZERO;
            sym_out  <= LVL_ZERO;
            sym_vld  <= 1'b0;
        end else if (chg) begin
            mode_q   <= mode;
            phase_q  <= 1'b0;
            st_q     <= '0;
            second_q <= LVL_ZERO;
            sym_vld  <= 1'b0;
        end else begin
            sym_vld <= half_tick;
            if (half_tick) begin
                phase_q <= ~phase_q;
                if (!phase_q) begin
                    sym_out  <= first_c;
                    second_q <= second_c;
                    st_q     <= st_nx;
                end else begin
                    sym_out <= second_q;
                end
            end
        end
    end

endmodule

// File: rtl/mcle_checks.sv
// Property checker for the line encoder, bound to the top. Keeps its own
// record of the half phase, the first-half symbol and the last AMI pulse,
// all restarted when the selector changes.
module mcle_checks
    import mcle_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       half_tick,
    input logic [3:0] mode,
    input logic [1:0] sym_out,
    input logic       sym_vld
);

    logic [3:0] ck_mode;
    logic       ck_half;
    level_t     ck_first;
    level_t     ck_last;
    logic       ck_seen;
    logic       is_hold;
    logic       is_split;
    logic       is_unused;

    // Classify the selector the current output was produced under.
    always_comb begin
        is_hold   = (ck_mode == CODE_NRZL) || (ck_mode == CODE_NRZI) ||
                    (ck_mode == CODE_AMI)  || (ck_mode == CODE_PSEUDO) ||
                    (ck_mode == CODE_SUB8) || (ck_mode == CODE_SUB4);
        is_split  = (ck_mode == CODE_MAN) || (ck_mode == CODE_DMAN);
        is_unused = (ck_mode == 4'd8) || (ck_mode > 4'd9);
    end

    // Shadow tracking of half phase, first-half level and last AMI pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_mode  <= CODE_RZ;
            ck_half  <= 1'b0;
            ck_first <= LVL_ZERO;
            ck_last  <= LVL_ZERO;
            ck_seen  <= 1'b0;
        end else if (mode != ck_mode) begin
            ck_mode  <= mode;
            ck_half  <= 1'b0;
            ck_first <= LVL_ZERO;
            ck_last  <= LVL_ZERO;
            ck_seen  <= 1'b0;
        end else if (sym_vld) begin
            ck_half <= ~ck_half;
            if (!ck_half) begin
                ck_first <= sym_out;
                if (ck_mode == CODE_AMI && sym_out != LVL_ZERO) begin
                    ck_last <= sym_out;
                    ck_seen <= 1'b1;
                end
            end
        end
    end

    assert_legal_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld |-> (sym_out != 2'b10));

    assert_vld_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld |-> $past(half_tick));

    assert_rz_second_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_vld && ck_half && ck_mode == CODE_RZ) |-> (sym_out == LVL_ZERO));

    assert_full_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_vld && ck_half && is_hold) |-> (sym_out == ck_first));

    assert_split_halves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_vld && ck_half && is_split) |-> (ck_first != LVL_ZERO && sym_out == invert(ck_first)));

    assert_ami_alternates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_vld && !ck_half && ck_mode == CODE_AMI && ck_seen && sym_out != LVL_ZERO)
            |-> (sym_out != ck_last));

    assert_unused_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_vld && is_unused) |-> (sym_out == LVL_ZERO));

endmodule

bind multicode_line_enc mcle_checks u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_tick (half_tick),
    .mode      (mode),
    .sym_out   (sym_out),
    .sym_vld   (sym_vld)
);

// File: tb/multicode_line_enc_test.sv
// Bench: every selector value is swept with streams that contain long zero runs,
// and expected symbols come from an arithmetic model written from the brief.
module multicode_line_enc_test;

    localparam int NB = 40;
    localparam logic [1:0] ZR = 2'b00;
    localparam logic [1:0] PS = 2'b01;
    localparam logic [1:0] NG = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0;
    logic       half_tick = 1'b0;
    logic [3:0] mode = 4'd0;
    logic [1:0] sym_out;
    logic       sym_vld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit         sb   [NB];
    int         role [NB];
    logic [1:0] e0   [NB];
    logic [1:0] e1   [NB];

    multicode_line_enc uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (bit_in),
        .half_tick (half_tick),
        .mode      (mode),
        .sym_out   (sym_out),
        .sym_vld   (sym_vld)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] m);
        case (m)
            4'd0: return "R3";
            4'd1, 4'd2: return "R4";
            4'd3: return "R5";
            4'd4: return "R6";
            4'd5: return "R7";
            4'd6: return "R8";
            4'd7: return "R9";
            4'd9: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Stream with LFSR bits, forced zero runs and an odd count of ones.
    task automatic gen(input logic [15:0] seed);
        logic [15:0] lf = seed;
        int ones = 0;
        for (int i = 0; i < NB; i++) begin
            sb[i] = lf[0];
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        end
        sb[4] = 1'b1;
        for (int i = 5; i < 17; i++) sb[i] = 1'b0;
        sb[17] = 1'b1;
        for (int i = 21; i < 26; i++) sb[i] = 1'b0;
        for (int i = 0; i < NB; i++) ones += int'(sb[i]);
        if ((ones % 2) == 0) sb[NB-1] = ~sb[NB-1];
    endtask

    // Expected symbols per bit period for selector m.
    task automatic model(input logic [3:0] m);
        bit pol = 0, par = 0, lvl = 0, dm = 0;
        int run = (m == 4'd7) ? 8 : 4;
        int zc = 0;
        for (int i = 0; i < NB; i++) role[i] = 0;
        if (m == 4'd7 || m == 4'd9) begin
            for (int i = 0; i < NB; i++) begin
                zc = sb[i] ? 0 : zc + 1;
                if (zc == run) begin
                    for (int r = 0; r < run; r++) role[i-run+1+r] = r + 1;
                    zc = 0;
                end
            end
        end
        for (int i = 0; i < NB; i++) begin
            bit b = sb[i];
            e0[i] = ZR; e1[i] = ZR;
            case (m)
                4'd0: e0[i] = b ? PS : ZR;
                4'd1: begin e0[i] = b ? NG : PS; e1[i] = e0[i]; end
                4'd2: begin lvl ^= b; e0[i] = lvl ? PS : NG; e1[i] = e0[i]; end
                4'd3: begin e0[i] = b ? PS : NG; e1[i] = b ? NG : PS; end
                4'd4: begin
                    e0[i] = (b ^ dm) ? PS : NG; e1[i] = (b ^ dm) ? NG : PS; dm ^= b;
                end
                4'd5, 4'd6: begin
                    if (b == (m == 4'd5)) begin e0[i] = pol ? NG : PS; pol ^= 1; end
                    e1[i] = e0[i];
                end
                4'd7, 4'd9: begin
                    if (i >= run) begin
                        int k = i - run;
                        int r = role[k];
                        if (sb[k]) begin
                            e0[i] = pol ? NG : PS; pol ^= 1; par ^= 1;
                        end else if (m == 4'd7) begin
                            if (r == 4 || r == 8) e0[i] = pol ? PS : NG;
                            else if (r == 5 || r == 7) e0[i] = pol ? NG : PS;
                        end else begin
                            if (r == 1 && !par) begin e0[i] = pol ? NG : PS; pol ^= 1; par = 1; end
                            else if (r == 4) begin e0[i] = pol ? PS : NG; par = 0; end
                        end
                    end
                    e1[i] = e0[i];
                end
                default: ;
            endcase
        end
    endtask

    // One strobe: returns the symbol and checks the strobe-to-valid timing.
    task automatic half(input bit b, output logic [1:0] s);
        @(negedge clk);
        half_tick = 1'b1;
        bit_in = b;
        @(negedge clk);
        half_tick = 1'b0;
        s = sym_out;
        chk("R2 valid after strobe", {1'b0, sym_vld}, 2'b01);
        chk("R1 legal level", (sym_out == 2'b10) ? 2'b10 : 2'b00, 2'b00);
        @(negedge clk);
        chk("R2 valid is one cycle", {1'b0, sym_vld}, 2'b00);
    endtask

    task automatic segment(input logic [3:0] m, input logic [15:0] seed);
        logic [1:0] s;
        int run = (m == 4'd7) ? 8 : ((m == 4'd9) ? 4 : 0);
        @(negedge clk);
        mode = m;
        repeat (2) @(negedge clk);
        gen(seed);
        model(m);
        for (int i = 0; i < NB; i++) begin
            string tag = (i < run) ? {req_of(m), " R12 fill"} :
                         ((i == 0) ? {req_of(m), " R11 fresh state"} : req_of(m));
            half(sb[i], s);
            chk({tag, " first half"}, s, e0[i]);
            half(sb[i], s);
            chk({tag, " second half"}, s, e1[i]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R2 reset valid low", {1'b0, sym_vld}, 2'b00);
        chk("R1 reset level zero", sym_out, ZR);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 idle valid low", {1'b0, sym_vld}, 2'b00);
        segment(4'd5, 16'hACE1);
        segment(4'd0, 16'h1234);
        segment(4'd5, 16'hBEEF);
        segment(4'd1, 16'h0F0F);
        segment(4'd2, 16'h5A5A);
        segment(4'd3, 16'hC3C3);
        segment(4'd4, 16'h9E37);
        segment(4'd6, 16'h7777);
        segment(4'd7, 16'h2468);
        segment(4'd9, 16'h1357);
        segment(4'd8, 16'hFFFF);
        segment(4'd10, 16'hAAAA);
        segment(4'd15, 16'h5555);
        segment(4'd7, 16'hD00D);
        segment(4'd9, 16'h8421);
        segment(4'd4, 16'h4321);
        segment(4'd9, 16'hF00F);
        segment(4'd2, 16'h6B6B);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule